// File: doc/BRIEF.md
# Gaussian Distance Accumulation Pipe

This block scores one component of a diagonal Gaussian mixture against a feature vector, entirely in fixed point. A component arrives as a stream of slots. Each of its d dimension slots carries a feature value, the mean for that dimension and a precomputed half inverse variance. A single closing slot then carries the component's constant term K and its log-domain mixture weight W. Two status bits ride with every slot: one marks the opening dimension and one marks the closing K/W slot. These bits steer the operand multiplexers, so no control state machine is needed.

For each dimension the pipe forms the squared difference between feature and mean, scales it by the precision and adds it into a saturating running distance. When the closing slot passes, the distance is taken from K and W is added, which gives the weighted log score. Each stage loads only when its predecessor presents valid data. An empty pipe therefore holds every register still until the next slot arrives. The arithmetic core is seven register stages deep. Padding stages bring the total latency up to a parameter (ten by default), so the score lines up with the stage that follows the pipe.

Top module: `gauss_dist_pipe`

## Requirements
- R1: While `rst` is high and after its release, before any slot has been scored, `out_valid` is 0 and `out_score` is 0.
- R2: Each dimension slot contributes floor((x - m)^2 * p / 2^FRAC), with FRAC = 16 by default. Here x is `in_feat` read as signed, m is `in_mean` read as signed and p is `in_prec` read as unsigned. The contributions of all dimension slots of a component are summed.
- R3: The running distance saturates at 2^ACC_W - 1 (2^32 - 1 by default) instead of wrapping. The per-dimension contribution is clamped to the same ceiling.
- R4: The closing slot is the slot with `in_last` = 1. It carries K as signed in `in_mean` and W as signed in `in_prec`, and `in_feat` is ignored. The score is K - distance + W, clamped to the signed ACC_W range and presented two's-complement on `out_score`.
- R5: A slot with `in_first` = 1 starts a new distance from zero. Nothing accumulated by an earlier component affects it.
- R6: `out_valid` is high for exactly one cycle per component. That cycle follows the LAT-th rising edge (10 by default), counting the edge that accepts the closing slot as the first.
- R7: Idle cycles (`in_valid` = 0) inserted between the slots of a component change neither its score nor the latency measured from its closing slot.
- R8: While `in_valid` is 0, the values on `in_first`, `in_last`, `in_feat`, `in_mean` and `in_prec` have no effect on any score.
- R9: While `out_valid` is 0, `out_score` keeps the value it had in the previous cycle.
- R10: Input protocol: each component has at least one dimension slot. `in_first` and `in_last` are never both set. At least one idle cycle follows every closing slot. Components that keep to exactly this minimal gap are all scored correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Slot present this cycle |
| in_first | input | 1 | Slot is the opening dimension of a component |
| in_last | input | 1 | Slot is the closing K/W slot |
| in_feat | input | DW (16) | Feature value, signed |
| in_mean | input | DW (16) | Mean (dimension slot) or K (closing slot), signed |
| in_prec | input | DW (16) | Precision, unsigned (dimension slot) or W, signed (closing slot) |
| out_valid | output | 1 | Score strobe, one cycle per component |
| out_score | output | ACC_W (32) | Weighted component score, signed |

## Verification
The sweeps place extreme feature/mean pairs at the largest precision so that the running distance saturates. A design that wrapped would return a large positive score where the low clamp is expected. Components are packed at the minimal one-cycle gap. In the shared adder the restart and the K subtraction are one cycle apart, so a design that mis-steered them would carry a stale distance into the next score. Idle cycles with random field and status values are inserted inside components, where a design that loaded on an invalid slot would add phantom terms or restart early. Every score is also checked against its exact arrival cycle, and the output is checked to hold during idle periods. A wrong padding depth or a repeated strobe therefore shows up as a latency or hold failure.

// File: rtl/gdp_pkg.sv
`timescale 1ns/1ps
package gdp_pkg;
  // Status carried with every slot through the pipe
  typedef struct packed {
    logic first;  // opening dimension of a component
    logic last;   // closing K/W slot
  } gdp_tag_t;

  // Register stages in the arithmetic core (before latency padding)
  localparam int GDP_CORE_STAGES = 7;
endpackage

// File: rtl/gdp_term_path.sv
`timescale 1ns/1ps
// Stages 1..4: input capture, difference, square, precision scale.
module gdp_term_path
  import gdp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ACC_W = 32,
  parameter int FRAC  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  gdp_tag_t         in_tag,
  input  logic [DW-1:0]    in_feat,
  input  logic [DW-1:0]    in_mean,
  input  logic [DW-1:0]    in_prec,
  output logic             t_valid,
  output gdp_tag_t         t_tag,
  output logic [ACC_W-1:0] t_term,
  output logic [DW-1:0]    t_k,
  output logic [DW-1:0]    t_w
);
  localparam int DIFF_W = DW + 1;
  localparam int SQ_W   = 2 * DIFF_W;
  localparam int PROD_W = SQ_W + DW;

  // stage 1
  logic                     v1;
  gdp_tag_t                 g1;
  logic signed [DW-1:0]     x1, m1;
  logic [DW-1:0]            p1;
  // stage 2
  logic                     v2;
  gdp_tag_t                 g2;
  logic signed [DIFF_W-1:0] diff2;
  logic [DW-1:0]            k2, p2;
  // stage 3
  logic                     v3;
  gdp_tag_t                 g3;
  logic [SQ_W-1:0]          sq3;
  logic [DW-1:0]            k3, p3;
  // stage 4
  logic                     v4;
  gdp_tag_t                 g4;
  logic [ACC_W-1:0]         term4;
  logic [DW-1:0]            k4, w4;

  logic signed [SQ_W-1:0]   dx;
  logic [PROD_W-1:0]        prod;
  logic [PROD_W-1:0]        shf;
  logic [ACC_W-1:0]         term_c;

  // Valid chain: a valid bit only moves when something is in flight
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      v4 <= 1'b0;
    end else begin
      if (in_valid | v1) v1 <= in_valid;
      if (v1 | v2)       v2 <= v1;
      if (v2 | v3)       v3 <= v2;
      if (v3 | v4)       v4 <= v3;
    end
  end

  // Data registers load only behind a valid predecessor (local stall)
  always_ff @(posedge clk) begin
    if (in_valid) begin
      g1 <= in_tag;
      x1 <= $signed(in_feat);
      m1 <= $signed(in_mean);
      p1 <= in_prec;
    end
    if (v1) begin
      g2    <= g1;
      diff2 <= DIFF_W'(x1) - DIFF_W'(m1);
      k2    <= m1;
      p2    <= p1;
    end
    if (v2) begin
      g3  <= g2;
      sq3 <= $unsigned(dx * dx);
      k3  <= k2;
      p3  <= p2;
    end
    if (v3) begin
      g4    <= g3;
      term4 <= term_c;
      k4    <= k3;
      w4    <= p3;
    end
  end

  always_comb begin
    dx   = SQ_W'(diff2);
    prod = PROD_W'(sq3) * PROD_W'(p3);
    shf  = prod >> FRAC;
  end

  generate
    if (PROD_W > ACC_W) begin : g_clamp
      always_comb term_c = (|shf[PROD_W-1:ACC_W]) ? {ACC_W{1'b1}} : shf[ACC_W-1:0];
    end else begin : g_fit
      always_comb term_c = ACC_W'(shf);
    end
  endgenerate

  assign t_valid = v4;
  assign t_tag   = g4;
  assign t_term  = term4;
  assign t_k     = k4;
  assign t_w     = w4;
endmodule

// File: rtl/gdp_accum.sv
`timescale 1ns/1ps
// Stages 5..7: shared-adder accumulation, K subtraction, weight add.
module gdp_accum
  import gdp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             t_valid,
  input  gdp_tag_t         t_tag,
  input  logic [ACC_W-1:0] t_term,
  input  logic [DW-1:0]    t_k,
  input  logic [DW-1:0]    t_w,
  output logic             s_valid,
  output logic [ACC_W-1:0] s_score
);
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] U_CEIL = {2'b00, {ACC_W{1'b1}}};
  localparam logic signed [SUM_W-1:0] S_TOP  = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] S_BOT  = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] A_CEIL = {ACC_W{1'b1}};
  localparam logic [ACC_W-1:0] A_TOP  = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] A_BOT  = {1'b1, {(ACC_W-1){1'b0}}};

  // stage 5
  logic                    v5, l5;
  logic [ACC_W-1:0]        acc;
  logic signed [DW-1:0]    k5, w5;
  // stage 6
  logic                    v6;
  logic signed [SUM_W-1:0] kd6;
  logic signed [DW-1:0]    w6;
  // stage 7
  logic                    v7;
  logic [ACC_W-1:0]        score7;

  logic                    kw_pend;
  logic signed [SUM_W-1:0] acc_x, op_a, op_b, sum, tot;
  logic [ACC_W-1:0]        acc_next, score_c;

  assign kw_pend = v5 & l5;

  // One adder serves restart, accumulation and the K subtraction; the
  // status bits and the pending closing slot pick its operands.
  always_comb begin
    acc_x = $signed({2'b00, acc});
    if (kw_pend) begin
      op_a = SUM_W'(k5);
      op_b = -acc_x;
    end else begin
      op_a = t_tag.first ? '0 : acc_x;
      op_b = $signed({2'b00, t_term});
    end
    sum      = op_a + op_b;
    acc_next = (sum > U_CEIL) ? A_CEIL : sum[ACC_W-1:0];

    tot = kd6 + SUM_W'(w6);
    if (tot > S_TOP)      score_c = A_TOP;
    else if (tot < S_BOT) score_c = A_BOT;
    else                  score_c = tot[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v5  <= 1'b0;
      l5  <= 1'b0;
      v6  <= 1'b0;
      v7  <= 1'b0;
      acc <= '0;
    end else begin
      if (t_valid | v5) v5 <= t_valid;
      if (t_valid) l5 <= t_tag.last;
      if (t_valid && !t_tag.last) acc <= acc_next;
      if (kw_pend | v6) v6 <= kw_pend;
      if (v6 | v7) v7 <= v6;
    end
  end

  always_ff @(posedge clk) begin
    if (t_valid && t_tag.last) begin
      k5 <= $signed(t_k);
      w5 <= $signed(t_w);
    end
    if (kw_pend) begin
      kd6 <= sum;
      w6  <= w5;
    end
    if (v6) score7 <= score_c;
  end

  assign s_valid = v7;
  assign s_score = score7;
endmodule

// File: rtl/gdp_delay_line.sv
`timescale 1ns/1ps
// Latency padding: DEPTH valid-gated register stages, reset to zero.
module gdp_delay_line #(
  parameter int DEPTH = 3,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic [DEPTH-1:0] v;
  logic [W-1:0]     d [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic         pv;
      logic [W-1:0] pd;
      if (i == 0) begin : g_head
        assign pv = in_v;
        assign pd = in_d;
      end else begin : g_link
        assign pv = v[i-1];
        assign pd = d[i-1];
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          v[i] <= 1'b0;
          d[i] <= '0;
        end else begin
          if (pv | v[i]) v[i] <= pv;
          if (pv) d[i] <= pd;
        end
      end
    end
  endgenerate

  assign out_v = v[DEPTH-1];
  assign out_d = d[DEPTH-1];
endmodule

// File: rtl/gauss_dist_pipe.sv
`timescale 1ns/1ps
module gauss_dist_pipe
  import gdp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ACC_W = 32,
  parameter int FRAC  = 16,
  parameter int LAT   = 10   // total register stages, at least 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [DW-1:0]    in_feat,
  input  logic [DW-1:0]    in_mean,
  input  logic [DW-1:0]    in_prec,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_score
);
  localparam int PAD = LAT - GDP_CORE_STAGES;

  gdp_tag_t         in_tag, t_tag;
  logic             t_valid, s_valid;
  logic [ACC_W-1:0] t_term, s_score;
  logic [DW-1:0]    t_k, t_w;

  assign in_tag.first = in_first;
  assign in_tag.last  = in_last;

  gdp_term_path #(.DW(DW), .ACC_W(ACC_W), .FRAC(FRAC)) u_term (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_tag  (in_tag),
    .in_feat (in_feat),
    .in_mean (in_mean),
    .in_prec (in_prec),
    .t_valid (t_valid),
    .t_tag   (t_tag),
    .t_term  (t_term),
    .t_k     (t_k),
    .t_w     (t_w)
  );

  gdp_accum #(.DW(DW), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .t_valid(t_valid),
    .t_tag  (t_tag),
    .t_term (t_term),
    .t_k    (t_k),
    .t_w    (t_w),
    .s_valid(s_valid),
    .s_score(s_score)
  );

  gdp_delay_line #(.DEPTH(PAD), .W(ACC_W)) u_pad (
    .clk  (clk),
    .rst  (rst),
    .in_v (s_valid),
    .in_d (s_score),
    .out_v(out_valid),
    .out_d(out_score)
  );
endmodule

// File: rtl/gauss_dist_pipe_chk.sv
`timescale 1ns/1ps
module gauss_dist_pipe_chk #(
  parameter int ACC_W = 32,
  parameter int LAT   = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_first,
  input logic             in_last,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_score
);
  // Trail of accepted closing slots, one bit per cycle
  logic [LAT-1:0] kw_trail;
  always_ff @(posedge clk) begin
    if (rst) kw_trail <= '0;
    else     kw_trail <= {kw_trail[LAT-2:0], in_valid & in_last};
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid == kw_trail[LAT-1]);

  p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_score_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_score));

  p_gap_after_close_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> !in_valid);

  p_tags_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !(in_first && in_last));
endmodule

bind gauss_dist_pipe gauss_dist_pipe_chk #(.ACC_W(ACC_W), .LAT(LAT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_first (in_first),
  .in_last  (in_last),
  .out_valid(out_valid),
  .out_score(out_score)
);

// File: tb/gauss_dist_pipe_tb.sv
`timescale 1ns/1ps
module gauss_dist_pipe_tb;
  localparam int DW = 16, ACC_W = 32, FRAC = 16, LAT = 10;
  localparam longint UCEIL = 64'sh0000_0000_FFFF_FFFF;
  localparam longint STOP  = 64'sh0000_0000_7FFF_FFFF;
  localparam longint SBOT  = -64'sh0000_0000_8000_0000;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid, in_first, in_last;
  logic [DW-1:0]    in_feat, in_mean, in_prec;
  logic             out_valid;
  logic [ACC_W-1:0] out_score;

  gauss_dist_pipe #(.DW(DW), .ACC_W(ACC_W), .FRAC(FRAC), .LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_feat(in_feat), .in_mean(in_mean),
    .in_prec(in_prec), .out_valid(out_valid), .out_score(out_score)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int     n_chk = 0, n_bad = 0;
  bit     finished = 1'b0;
  longint exp_q[$];
  int     due_q[$];
  string  tag_q[$];
  longint held = 0;
  longint m_exp;
  int     m_due;
  string  m_tag;
  int     vx[16], vm[16], vp[16];

  task automatic note(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // R2/R3 model of one dimension contribution
  function automatic longint term_of(longint x, longint m, longint p);
    longint dd;
    longint t;
    dd = x - m;
    t  = ((dd * dd) * p) >>> FRAC;
    if (t > UCEIL) t = UCEIL;
    return t;
  endfunction

  function automatic longint clamp_s(longint v);
    if (v > STOP) return STOP;
    if (v < SBOT) return SBOT;
    return v;
  endfunction

  task automatic put(bit v, bit f, bit l, int x, int m, int p);
    @(negedge clk);
    in_valid = v;
    in_first = f;
    in_last  = l;
    in_feat  = x[DW-1:0];
    in_mean  = m[DW-1:0];
    in_prec  = p[DW-1:0];
  endtask

  // Idle cycles with random fields and status bits (R8)
  task automatic idle(int n);
    for (int i = 0; i < n; i++)
      put(1'b0, 1'($urandom_range(1)), 1'($urandom_range(1)),
          int'($urandom), int'($urandom), int'($urandom));
  endtask

  task automatic comp(int d, int k, int w, int bub, string tag);
    longint acc;
    longint t;
    acc = 0;
    for (int i = 0; i < d; i++) begin
      t   = term_of(vx[i], vm[i], vp[i]);
      acc = (i == 0) ? t : acc + t;
      if (acc > UCEIL) acc = UCEIL;
      put(1'b1, i == 0, 1'b0, vx[i], vm[i], vp[i]);
      if (bub > 0 && i < d - 1) idle(bub);
    end
    put(1'b1, 1'b0, 1'b1, int'($urandom), k, w);
    exp_q.push_back(clamp_s(longint'(k) - acc + longint'(w)));
    due_q.push_back(cyc + LAT);
    tag_q.push_back(tag);
    idle(1);
  endtask

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          note(1'b0, "R6 unexpected strobe", 1, 0);
        end else begin
          m_exp = exp_q.pop_front();
          m_due = due_q.pop_front();
          m_tag = tag_q.pop_front();
          note(longint'($signed(out_score)) == m_exp, m_tag,
               longint'($signed(out_score)), m_exp);
          note(cyc == m_due, "R6 latency", cyc, m_due);
        end
        held = longint'($signed(out_score));
      end else begin
        note(longint'($signed(out_score)) == held, "R9 hold",
             longint'($signed(out_score)), held);
      end
    end
  end

  initial begin
    #3_000_000;
    note(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int d;
    rst = 1'b1;
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    in_feat = '0; in_mean = '0; in_prec = '0;
    repeat (3) @(negedge clk);
    note(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    note(out_score == '0, "R1 out_score", out_score, 0);
    @(negedge clk);
    rst = 1'b0;

    // R2: single dimension: (100-40)^2 * 0x8000 >> 16 = 1800; 500-1800-20
    vx[0] = 100; vm[0] = 40; vp[0] = 32768;
    comp(1, 500, -20, 0, "R2 single dim");
    note(clamp_s(500 - 1800 - 20) == -1320, "R2 model", clamp_s(500 - 1800 - 20), -1320);

    // R2: several dimensions with signed features
    vx[0] = -300; vm[0] = 200;  vp[0] = 65535;
    vx[1] = 7;    vm[1] = -9;   vp[1] = 1;
    vx[2] = 1000; vm[2] = 1000; vp[2] = 40000;
    comp(3, -1234, 321, 2, "R2 multi dim");

    // R3/R4: extreme pairs saturate the distance, score clamps low
    vx[0] = 32767; vm[0] = -32768; vp[0] = 65535;
    vx[1] = -32768; vm[1] = 32767; vp[1] = 65535;
    comp(2, 0, 0, 0, "R3 R4 saturation");

    // R5: restart right after a saturated component
    vx[0] = 55; vm[0] = 55; vp[0] = 65535;
    comp(1, 7, 3, 0, "R5 restart");

    // R10: back-to-back components at the minimal gap
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < 2; i++) begin
        vx[i] = 1000 * n - 2500 + i; vm[i] = 17 * i; vp[i] = 300 + 4000 * n;
      end
      comp(1 + (n % 2), 100 * n, -50 * n, 0, "R10 minimal gap");
    end

    // R7 R8: idle cycles with random fields inside a component
    for (int i = 0; i < 5; i++) begin
      vx[i] = 400 * i - 800; vm[i] = -33 * i; vp[i] = 12000 + i;
    end
    comp(5, 2000, -7, 3, "R7 R8 bubbles");

    // R2/R3/R4 sweep over dimension counts and value ranges
    for (int n = 0; n < 300; n++) begin
      d = 1 + (n % 8);
      for (int i = 0; i < d; i++) begin
        if (n % 7 == 0) begin
          vx[i] = int'($urandom_range(65535)) - 32768;
          vm[i] = int'($urandom_range(65535)) - 32768;
        end else begin
          vx[i] = int'($urandom_range(2000)) - 1000;
          vm[i] = int'($urandom_range(2000)) - 1000;
        end
        vp[i] = int'($urandom_range(65535));
      end
      comp(d, int'($urandom_range(65535)) - 32768,
           int'($urandom_range(65535)) - 32768,
           (n % 3 == 0) ? int'($urandom_range(3)) : 0, "R2 R4 sweep");
    end

    // R9: long idle period, monitor checks the held score each cycle
    idle(40);
    note(exp_q.size() == 0, "R6 every component scored", exp_q.size(), 0);
    finish_run();
  end
endmodule